// File: doc/BRIEF.md
# Single-Stage Elastic Mesh Router

This block is a five-port packet router for a two-dimensional mesh of up to 8x8 nodes. Each node has one local terminal. The ports are local, north, south, east and west. The inputs have no storage: each input is fed straight from an upstream elastic channel with a valid/ready handshake. Each output feeds a two-slot elastic buffer, and that buffer drives the downstream channel.

A head flit already carries the output it needs at this router. That field was written by the previous hop. In a single cycle the router does three things:

- Each output runs its own round-robin arbiter over the inputs that request it.
- Winning flits cross a grant-selected AND-OR multiplexer switch into the output buffers.
- In parallel, look-ahead logic works out which output the packet will need at the next router. It uses X-then-Y dimension-order routing and writes the result into the routing field of the departing head flit.

Arbitration is per packet. Once an output admits a head flit, it stays with that input until the packet's tail has crossed. The flits of different packets therefore never interleave on one output. The router's own mesh coordinates are parameters.

Top module: `eb_router`

Flit layout, LSB first:

| Bits | Field | Encoding |
|---|---|---|
| [1:0] | kind | 00 body, 01 head, 10 tail, 11 single-flit packet (bit 0 marks head, bit 1 marks tail) |
| [4:2] | routing field | 0 local, 1 north (Y+1), 2 south (Y-1), 3 east (X+1), 4 west (X-1) |
| [7:5] | destination X | |
| [10:8] | destination Y | |
| above [10] | payload | |

States and transitions:

- **Arbiter, per output:**
  - `ARB_IDLE` to `ARB_LOCKED` when a multi-flit head is granted.
  - `ARB_IDLE` stays in `ARB_IDLE` when a single-flit packet is granted, or when nothing is granted.
  - `ARB_LOCKED` stays in `ARB_LOCKED` while body flits of the owner pass, or while the owner stalls.
  - `ARB_LOCKED` to `ARB_IDLE` when the owner's tail is granted.
- **Output buffer:**
  - `EB_EMPTY` to `EB_ONE` on a push.
  - `EB_ONE` to `EB_TWO` on a push without a pop.
  - `EB_ONE` to `EB_EMPTY` on a pop without a push.
  - `EB_ONE` stays in `EB_ONE` on a push together with a pop.
  - `EB_TWO` to `EB_ONE` on a pop.

## Requirements
- R1: After reset with no input valid, all `out_valid` bits and all `in_ready` bits are 0.
- R2: A head or single flit accepted on any input appears on the output named by its routing field, on `out_valid`/`out_flit`, one clock edge after the accepting edge.
- R3: Body and tail flits go to the output recorded from their packet's head, whatever their own routing field holds, and they leave with all bits unchanged.
- R4: A departing head flit carries in its routing field the next router's output. That output is found by stepping one hop in the chosen direction and then applying dimension-order routing: X first (east if destination X is larger, west if smaller), then Y (north if larger, south if smaller), and local when both coordinates match. A head leaving through the local port carries 0.
- R5: An output is granted only while its output buffer can accept a flit. A buffer holding two flits deasserts its acceptance, so the third competing flit waits.
- R6: An idle output grants one requesting head per cycle, in round-robin order. The search starts at the input after the last winner on that output.
- R7: While a multi-flit packet holds an output, no other input is granted that output until the tail has crossed.
- R8: A single-flit packet takes and frees its output in the cycle it crosses, so another input can be granted that output on the next cycle.
- R9: `in_ready` of an input is 1 exactly in the cycle its flit crosses the switch, and never without `in_valid`.
- R10: An output buffer keeps its head flit stable while `out_ready` is low, and it releases flits in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_flit | input | 5 x FLIT_W | Flit offered on each input (index = port code) |
| in_valid | input | 5 | Input flit valid |
| in_ready | output | 5 | Input flit taken this cycle |
| out_flit | output | 5 x FLIT_W | Flit at the head of each output buffer |
| out_valid | output | 5 | Output buffer holds a flit |
| out_ready | input | 5 | Downstream accepts the output flit |

## Verification
`in_ready` is combinational, so the bench sets the inputs at the falling edge and samples `in_ready` one nanosecond later, before the rising edge that acts on it. Output flits pass through exactly one register, the output buffer. Each accepted flit is therefore checked on `out_flit` at the next falling edge, one rising edge after acceptance. A stalled buffer's contents are rechecked on every falling edge until `out_ready` returns. After a stall is released, the flit that was refused is expected to be taken one cycle later, because the buffer's acceptance is itself registered.

// File: rtl/ebr_pkg.sv
`timescale 1ns/1ps
package ebr_pkg;
    localparam int NPORT   = 5;
    localparam int COORD_W = 3;
    localparam int PORT_W  = 3;
    localparam int KIND_W  = 2;
    localparam int HDR_W   = KIND_W + PORT_W + 2 * COORD_W;

    typedef enum logic [PORT_W-1:0] {
        PORT_LOCAL = 3'd0,
        PORT_NORTH = 3'd1,
        PORT_SOUTH = 3'd2,
        PORT_EAST  = 3'd3,
        PORT_WEST  = 3'd4
    } port_e;

    // X-then-Y choice of output at a router sitting at (cx, cy)
    function automatic logic [PORT_W-1:0] dor_pick(
        input logic [COORD_W-1:0] dx, input logic [COORD_W-1:0] dy,
        input logic [COORD_W-1:0] cx, input logic [COORD_W-1:0] cy);
        if (dx > cx)      return PORT_EAST;
        else if (dx < cx) return PORT_WEST;
        else if (dy > cy) return PORT_NORTH;
        else if (dy < cy) return PORT_SOUTH;
        else              return PORT_LOCAL;
    endfunction

    // Coordinates {y, x} of the neighbour reached through port p
    function automatic logic [2*COORD_W-1:0] hop_pos(
        input logic [PORT_W-1:0] p,
        input logic [COORD_W-1:0] cx, input logic [COORD_W-1:0] cy);
        logic [COORD_W-1:0] nx, ny;
        nx = cx;
        ny = cy;
        case (p)
            PORT_NORTH: ny = cy + COORD_W'(1);
            PORT_SOUTH: ny = cy - COORD_W'(1);
            PORT_EAST:  nx = cx + COORD_W'(1);
            PORT_WEST:  nx = cx - COORD_W'(1);
            default: ;
        endcase
        return {ny, nx};
    endfunction
endpackage

// File: rtl/ebr_in_port.sv
`timescale 1ns/1ps
module ebr_in_port import ebr_pkg::*; #(
    parameter int FLIT_W = 27,
    parameter int X_POS  = 0,
    parameter int Y_POS  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLIT_W-1:0] in_flit,
    input  logic              in_valid,
    input  logic              taken,
    output logic [PORT_W-1:0] req_port,
    output logic              is_head,
    output logic              is_tail,
    output logic [FLIT_W-1:0] fwd_flit
);
    localparam int PT_LO = KIND_W;
    localparam int DX_LO = PT_LO + PORT_W;
    localparam int DY_LO = DX_LO + COORD_W;
    localparam logic [COORD_W-1:0] MY_X = COORD_W'(X_POS);
    localparam logic [COORD_W-1:0] MY_Y = COORD_W'(Y_POS);

    logic [PORT_W-1:0]    dest_q;
    logic [PORT_W-1:0]    here_port;
    logic [2*COORD_W-1:0] next_pos;
    logic [PORT_W-1:0]    next_port;

    assign is_head   = in_flit[0];
    assign is_tail   = in_flit[1];
    assign here_port = in_flit[PT_LO +: PORT_W];
    assign req_port  = is_head ? here_port : dest_q;

    // Per-input destination register, loaded when a head crosses
    always_ff @(posedge clk) begin
        if (!rst_n)                           dest_q <= PORT_LOCAL;
        else if (in_valid && taken && is_head) dest_q <= here_port;
    end

    // Look-ahead route for the next hop, computed beside arbitration
    always_comb begin
        next_pos  = hop_pos(here_port, MY_X, MY_Y);
        next_port = (here_port == PORT_LOCAL) ? PORT_LOCAL :
                    dor_pick(in_flit[DX_LO +: COORD_W], in_flit[DY_LO +: COORD_W],
                             next_pos[COORD_W-1:0], next_pos[2*COORD_W-1:COORD_W]);
        fwd_flit = in_flit;
        if (is_head) fwd_flit[PT_LO +: PORT_W] = next_port;
    end

    assert_take_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> in_valid);
endmodule

// File: rtl/ebr_arbiter.sv
`timescale 1ns/1ps
module ebr_arbiter #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] req_head,
    input  logic [N-1:0] req_tail,
    input  logic         buf_ready,
    output logic [N-1:0] gnt
);
    localparam int IDX_W = $clog2(N);

    typedef enum logic {ARB_IDLE, ARB_LOCKED} arb_state_e;

    arb_state_e       state_q, state_d;
    logic [N-1:0]     owner_q, owner_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic [N-1:0]     pick;
    logic [IDX_W-1:0] win_idx;
    logic             found;
    logic [IDX_W:0]   scan;

    // Round-robin search among requesting heads, starting at ptr_q
    always_comb begin
        pick    = '0;
        found   = 1'b0;
        win_idx = '0;
        scan    = '0;
        for (int k = 0; k < N; k++) begin
            scan = {1'b0, ptr_q} + (IDX_W+1)'(k);
            if (scan >= (IDX_W+1)'(N)) scan = scan - (IDX_W+1)'(N);
            if (!found && req[scan[IDX_W-1:0]] && req_head[scan[IDX_W-1:0]]) begin
                found = 1'b1;
                pick[scan[IDX_W-1:0]] = 1'b1;
                win_idx = scan[IDX_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            owner_q <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        gnt     = '0;
        state_d = state_q;
        owner_d = owner_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (found && buf_ready) begin
                    gnt   = pick;
                    ptr_d = (win_idx == IDX_W'(N-1)) ? '0 : win_idx + IDX_W'(1);
                    if (!(|(pick & req_tail))) begin
                        state_d = ARB_LOCKED;
                        owner_d = pick;
                    end
                end
            end
            ARB_LOCKED: begin
                if (buf_ready && |(owner_q & req)) begin
                    gnt = owner_q;
                    if (|(owner_q & req_tail)) state_d = ARB_IDLE;
                end
            end
        endcase
    end

    assert_grant_needs_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |-> buf_ready);
    assert_one_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    assert_no_interleave_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt) && !(|(gnt & req_tail))) |=> ((gnt & ~$past(gnt)) == '0));
    assert_single_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_IDLE && |(gnt & req_head & req_tail)) |=> state_q == ARB_IDLE);
endmodule

// File: rtl/ebr_out_buf.sv
`timescale 1ns/1ps
module ebr_out_buf #(
    parameter int W = 27
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_ready
);
    typedef enum logic [1:0] {EB_EMPTY, EB_ONE, EB_TWO} eb_state_e;

    eb_state_e    state_q, state_d;
    logic [W-1:0] hd_q, tl_q;
    logic         push, pop, ld_hd_in, ld_hd_tl, ld_tl;

    assign in_ready  = (state_q != EB_TWO);
    assign out_valid = (state_q != EB_EMPTY);
    assign out_data  = hd_q;
    assign push      = in_valid && in_ready;
    assign pop       = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EB_EMPTY;
            hd_q    <= '0;
            tl_q    <= '0;
        end else begin
            state_q <= state_d;
            if (ld_hd_in)      hd_q <= in_data;
            else if (ld_hd_tl) hd_q <= tl_q;
            if (ld_tl)         tl_q <= in_data;
        end
    end

    always_comb begin
        state_d  = state_q;
        ld_hd_in = 1'b0;
        ld_hd_tl = 1'b0;
        ld_tl    = 1'b0;
        unique case (state_q)
            EB_EMPTY: if (push) begin state_d = EB_ONE; ld_hd_in = 1'b1; end
            EB_ONE: begin
                if (push && pop)  ld_hd_in = 1'b1;
                else if (push)    begin state_d = EB_TWO; ld_tl = 1'b1; end
                else if (pop)     state_d = EB_EMPTY;
            end
            EB_TWO: if (pop) begin state_d = EB_ONE; ld_hd_tl = 1'b1; end
            default: state_d = EB_EMPTY;
        endcase
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> in_ready);
    assert_hold_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/eb_router.sv
`timescale 1ns/1ps
module eb_router import ebr_pkg::*; #(
    parameter  int PAYLOAD_W = 16,
    parameter  int X_POS     = 3,
    parameter  int Y_POS     = 4,
    localparam int FLIT_W    = HDR_W + PAYLOAD_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPORT-1:0][FLIT_W-1:0] in_flit,
    input  logic [NPORT-1:0]             in_valid,
    output logic [NPORT-1:0]             in_ready,
    output logic [NPORT-1:0][FLIT_W-1:0] out_flit,
    output logic [NPORT-1:0]             out_valid,
    input  logic [NPORT-1:0]             out_ready
);
    logic [NPORT-1:0][PORT_W-1:0] req_port;
    logic [NPORT-1:0]             head_v, tail_v, ob_ready, sw_valid;
    logic [NPORT-1:0][FLIT_W-1:0] fwd, sw_flit;
    logic [NPORT-1:0][NPORT-1:0]  req_m, gnt_m;   // [output][input]

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        ebr_in_port #(.FLIT_W(FLIT_W), .X_POS(X_POS), .Y_POS(Y_POS)) u_in (
            .clk(clk), .rst_n(rst_n), .in_flit(in_flit[i]), .in_valid(in_valid[i]),
            .taken(in_ready[i]), .req_port(req_port[i]), .is_head(head_v[i]),
            .is_tail(tail_v[i]), .fwd_flit(fwd[i]));
    end

    always_comb begin
        for (int o = 0; o < NPORT; o++)
            for (int i = 0; i < NPORT; i++)
                req_m[o][i] = in_valid[i] && (req_port[i] == PORT_W'(o));
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        ebr_arbiter #(.N(NPORT)) u_arb (
            .clk(clk), .rst_n(rst_n), .req(req_m[o]), .req_head(head_v),
            .req_tail(tail_v), .buf_ready(ob_ready[o]), .gnt(gnt_m[o]));
        ebr_out_buf #(.W(FLIT_W)) u_buf (
            .clk(clk), .rst_n(rst_n), .in_valid(sw_valid[o]), .in_data(sw_flit[o]),
            .in_ready(ob_ready[o]), .out_valid(out_valid[o]), .out_data(out_flit[o]),
            .out_ready(out_ready[o]));
    end

    // Grant-selected AND-OR multiplexer switch, one per output
    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            sw_flit[o]  = '0;
            sw_valid[o] = |gnt_m[o];
            for (int i = 0; i < NPORT; i++)
                if (gnt_m[o][i]) sw_flit[o] = sw_flit[o] | fwd[i];
        end
    end

    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            in_ready[i] = 1'b0;
            for (int o = 0; o < NPORT; o++) in_ready[i] = in_ready[i] | gnt_m[o][i];
        end
    end
endmodule

// File: tb/sim_eb_router.sv
`timescale 1ns/1ps
module sim_eb_router;
    import ebr_pkg::*;
    localparam int PW = 16;
    localparam int FW = HDR_W + PW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [4:0][FW-1:0] in_flit, out_flit;
    logic [4:0] in_valid, in_ready, out_valid, out_ready;

    eb_router #(.PAYLOAD_W(PW), .X_POS(3), .Y_POS(4)) u0 (
        .clk(clk), .rst_n(rst_n), .in_flit(in_flit), .in_valid(in_valid),
        .in_ready(in_ready), .out_flit(out_flit), .out_valid(out_valid),
        .out_ready(out_ready));

    int n_chk = 0, n_bad = 0, cyc = 0;

    // {input, routing field, dest X, dest Y, expected next-hop field}; router at (3,4)
    localparam logic [14:0] VEC [10] = '{
        {3'd0, 3'd3, 3'd6, 3'd4, 3'd3},
        {3'd1, 3'd3, 3'd4, 3'd4, 3'd0},
        {3'd2, 3'd4, 3'd0, 3'd7, 3'd4},
        {3'd3, 3'd1, 3'd3, 3'd7, 3'd1},
        {3'd4, 3'd2, 3'd3, 3'd0, 3'd2},
        {3'd0, 3'd1, 3'd3, 3'd5, 3'd0},
        {3'd1, 3'd0, 3'd3, 3'd4, 3'd0},
        {3'd2, 3'd3, 3'd4, 3'd1, 3'd2},
        {3'd3, 3'd4, 3'd2, 3'd6, 3'd1},
        {3'd4, 3'd2, 3'd5, 3'd0, 3'd3}
    };

    function automatic logic [FW-1:0] mk(input logic [1:0] k, input logic [2:0] p,
        input logic [2:0] dx, input logic [2:0] dy, input logic [PW-1:0] pl);
        return {pl, dy, dx, p, k};
    endfunction

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] t_in, t_pt, t_dx, t_dy, t_nh;
        logic [PW-1:0] pl;
        in_flit   = '0;
        in_valid  = '0;
        out_ready = '1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        #1;
        check("R1 out_valid after reset", 64'(out_valid), 64'(0));
        check("R1 in_ready after reset", 64'(in_ready), 64'(0));

        // Vector table: single-flit packets, one at a time
        for (int e = 0; e < 10; e++) begin
            {t_in, t_pt, t_dx, t_dy, t_nh} = VEC[e];
            pl = 16'hA000 + PW'(e);
            in_flit[t_in]  = mk(2'b11, t_pt, t_dx, t_dy, pl);
            in_valid       = 5'b1 << t_in;
            #1;
            check("R9 granted input ready", 64'(in_ready), 64'(5'b1 << t_in));
            tick();
            in_valid = '0;
            check("R2 output selected", 64'(out_valid), 64'(5'b1 << t_pt));
            check("R4 look-ahead field", 64'(out_flit[t_pt]), 64'(mk(2'b11, t_nh, t_dx, t_dy, pl)));
            tick();
            check("R10 buffer drained", 64'(out_valid), 64'(0));
        end

        // Round robin on north: pointer after table is 1, so input 4 wins first
        in_flit[0] = mk(2'b11, 3'd1, 3'd3, 3'd6, 16'hB000);
        in_flit[4] = mk(2'b11, 3'd1, 3'd3, 3'd5, 16'hB004);
        in_valid   = 5'b10001;
        #1;
        check("R6 round-robin winner", 64'(in_ready), 64'(5'b10000));
        tick();
        check("R6 winner flit", 64'(out_flit[1]), 64'(mk(2'b11, 3'd0, 3'd3, 3'd5, 16'hB004)));
        in_valid = 5'b00001;
        #1;
        check("R8 output free next cycle", 64'(in_ready), 64'(5'b00001));
        tick();
        in_valid = '0;
        check("R8 second packet out", 64'(out_flit[1]), 64'(mk(2'b11, 3'd1, 3'd3, 3'd6, 16'hB000)));
        tick();

        // Packet lock on east: input 0 three-flit packet, input 1 waits
        in_flit[0] = mk(2'b01, 3'd3, 3'd6, 3'd4, 16'hC000);
        in_flit[1] = mk(2'b11, 3'd3, 3'd4, 3'd4, 16'hC009);
        in_valid   = 5'b00011;
        #1;
        check("R7 head wins", 64'(in_ready), 64'(5'b00001));
        tick();
        check("R4 head rewritten", 64'(out_flit[3]), 64'(mk(2'b01, 3'd3, 3'd6, 3'd4, 16'hC000)));
        in_flit[0] = mk(2'b00, 3'd6, 3'd0, 3'd0, 16'hC001);
        #1;
        check("R7 body holds output", 64'(in_ready), 64'(5'b00001));
        tick();
        check("R3 body unchanged", 64'(out_flit[3]), 64'(mk(2'b00, 3'd6, 3'd0, 3'd0, 16'hC001)));
        in_flit[0] = mk(2'b10, 3'd5, 3'd0, 3'd0, 16'hC002);
        #1;
        check("R7 tail holds output", 64'(in_ready), 64'(5'b00001));
        tick();
        check("R3 tail unchanged", 64'(out_flit[3]), 64'(mk(2'b10, 3'd5, 3'd0, 3'd0, 16'hC002)));
        in_valid = 5'b00010;
        #1;
        check("R7 released after tail", 64'(in_ready), 64'(5'b00010));
        tick();
        in_valid = '0;
        check("R2 waiting packet out", 64'(out_flit[3]), 64'(mk(2'b11, 3'd0, 3'd4, 3'd4, 16'hC009)));
        tick();

        // Stall on east: buffer holds two, third waits
        out_ready[3] = 1'b0;
        in_flit[0] = mk(2'b11, 3'd3, 3'd6, 3'd4, 16'hD000);
        in_valid   = 5'b00001;
        #1;
        check("R5 first accepted", 64'(in_ready), 64'(5'b00001));
        tick();
        in_flit[0] = mk(2'b11, 3'd3, 3'd6, 3'd4, 16'hD001);
        #1;
        check("R5 second accepted", 64'(in_ready), 64'(5'b00001));
        tick();
        in_flit[0] = mk(2'b11, 3'd3, 3'd6, 3'd4, 16'hD002);
        #1;
        check("R5 full buffer refuses", 64'(in_ready), 64'(0));
        check("R10 head held", 64'(out_flit[3]), 64'(mk(2'b11, 3'd3, 3'd6, 3'd4, 16'hD000)));
        tick();
        check("R10 head stable", 64'(out_flit[3]), 64'(mk(2'b11, 3'd3, 3'd6, 3'd4, 16'hD000)));
        out_ready[3] = 1'b1;
        #1;
        check("R5 still full", 64'(in_ready), 64'(0));
        tick();
        check("R10 second in order", 64'(out_flit[3]), 64'(mk(2'b11, 3'd3, 3'd6, 3'd4, 16'hD001)));
        check("R5 room after pop", 64'(in_ready), 64'(5'b00001));
        tick();
        in_valid = '0;
        check("R10 third in order", 64'(out_flit[3]), 64'(mk(2'b11, 3'd3, 3'd6, 3'd4, 16'hD002)));
        tick();
        check("R10 empty at end", 64'(out_valid), 64'(0));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule